// File: doc/BRIEF.md
# Peripheral Clock Prescaler and Gate Controller

The block runs entirely in the system clock domain and hands out clock-enable strobes rather than clocks. It has two programmable prescalers, one for high-speed and one for low-speed peripherals. A field value of n divides the system clock by 2n, and a value of zero lets the strobe through on every cycle. A separate pair of ticks paces an external memory interface. The timing tick runs at the full rate or at half rate. The output tick follows the timing tick or every second one of them, and it can be switched off.

Three enable registers hold one clock-enable bit for each peripheral. The same bits decide whether a peripheral-side register access goes through. An access to a disabled peripheral produces no read or write strobe, and a read from it returns zero. The PWM timebase enables come from the second enable register, but they stay low until a global sync bit is set. That lets every enabled timebase start on the same cycle.

All setup is done through a small register port. Address 0 holds the high-speed prescaler field and address 1 holds the low-speed one. Address 2 is the interface/sync control register. Addresses 3, 4 and 5 are the three enable groups. Addresses 6 and 7 are unused.

Top module: `pclk_gate`

## Requirements
- R1: After reset, the high-speed prescaler field reads 1 and the low-speed field reads 2. The control register and all three enable groups read 0, and every enable output is low.
- R2: When a prescaler field holds n > 0, its strobe is high for one cycle in every 2n cycles. The first strobe after reset comes in cycle 2n-1 when cycles are counted from 0.
- R3: When a prescaler field holds 0, its strobe is high on every cycle.
- R4: Writing a prescaler field (address 0 for high-speed, address 1 for low-speed) restarts its count. The cycle after the write edge is cycle 0, and the first strobe comes in cycle 2n-1. Only bits [PS_W-1:0] of the write data are kept.
- R5: Control bit 0 selects the timing tick. At 0 the tick is high on every cycle. At 1 it is high in cycles 1, 3, 5 and so on, counted from reset or from the last control write.
- R6: Control bit 1 selects the output tick. At 0 it follows the timing tick. At 1 it fires only on every second timing tick, starting with the second one after reset or after the last control write. Control bit 2 set to 1 forces the output tick low.
- R7: A write to address 3, 4 or 5 loads enable group 0, 1 or 2. Group k drives `periph_en[k*REG_W +: REG_W]` and reads back at the same address.
- R8: PWM timebase enable j equals `periph_en[REG_W+j]` while control bit 3 (sync) is 1, and it is 0 while sync is 0. Setting sync raises every enabled timebase on the same cycle.
- R9: A peripheral access with index `pa_id` raises only strobe bit `pa_id`, and only if that peripheral is enabled. An index of NP or more raises no strobe.
- R10: `pa_rdata_out` passes `pa_rdata_in` only on a read of an enabled peripheral, and is 0 otherwise.
- R11: Writes to addresses 6 and 7 change no register and do not restart any count. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| hs_stb | output | 1 | High-speed prescaled strobe |
| ls_stb | output | 1 | Low-speed prescaled strobe |
| xtim_stb | output | 1 | External interface timing tick |
| xout_stb | output | 1 | External output clock tick |
| periph_en | output | 3*REG_W | Per-peripheral clock enables |
| pwm_tb_en | output | N_PWM | Synchronised PWM timebase enables |
| acc_ok | output | 3*REG_W | Per-peripheral access allowed |
| pa_rd | input | 1 | Peripheral-side read request |
| pa_wr | input | 1 | Peripheral-side write request |
| pa_id | input | clog2(3*REG_W) | Target peripheral index |
| pa_rdata_in | input | DW | Read data from the addressed peripheral |
| pa_rdata_out | output | DW | Gated read data |
| pa_rd_stb | output | 3*REG_W | Per-peripheral read strobe |
| pa_wr_stb | output | 3*REG_W | Per-peripheral write strobe |

## Verification
The bench builds the block with PS_W=3, REG_W=8, N_PWM=4 and DW=16. Each prescaler then tops out at a divide by 14, which is short enough to cover every field value and repeated restarts in a few hundred cycles. With 24 peripherals, the bench can reach enabled and disabled indices in every group, the PWM slice inside group 1, and the out-of-range indices 24 to 31 of the 5-bit `pa_id`.

// File: rtl/pclk_gate.sv
module pclk_gate #(
  parameter int PS_W   = 3,
  parameter int REG_W  = 16,
  parameter int N_PWM  = 6,
  parameter int DW     = 16,
  parameter int HS_RST = 1,
  parameter int LS_RST = 2,
  localparam int NP    = 3 * REG_W,
  localparam int PID_W = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             hs_stb,
  output logic             ls_stb,
  output logic             xtim_stb,
  output logic             xout_stb,
  output logic [NP-1:0]    periph_en,
  output logic [N_PWM-1:0] pwm_tb_en,
  output logic [NP-1:0]    acc_ok,
  input  logic             pa_rd,
  input  logic             pa_wr,
  input  logic [PID_W-1:0] pa_id,
  input  logic [DW-1:0]    pa_rdata_in,
  output logic [DW-1:0]    pa_rdata_out,
  output logic [NP-1:0]    pa_rd_stb,
  output logic [NP-1:0]    pa_wr_stb
);
  localparam int CW = PS_W + 1;

  logic [PS_W-1:0] hs_div, ls_div;
  logic [CW-1:0]   hs_cnt, ls_cnt;
  logic [3:0]      ctrl;
  logic [NP-1:0]   en;
  logic            tph, oph;

  wire wr_hs   = reg_we && reg_addr == 3'd0;
  wire wr_ls   = reg_we && reg_addr == 3'd1;
  wire wr_ctrl = reg_we && reg_addr == 3'd2;

  wire [CW-1:0] hs_last = {hs_div, 1'b0} - CW'(1);
  wire [CW-1:0] ls_last = {ls_div, 1'b0} - CW'(1);

  assign hs_stb = (hs_div == '0) || (hs_cnt == hs_last);
  assign ls_stb = (ls_div == '0) || (ls_cnt == ls_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_div <= PS_W'(HS_RST);
      hs_cnt <= '0;
    end else if (wr_hs) begin
      hs_div <= reg_wdata[PS_W-1:0];
      hs_cnt <= '0;
    end else if (hs_stb) hs_cnt <= '0;
    else hs_cnt <= hs_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_div <= PS_W'(LS_RST);
      ls_cnt <= '0;
    end else if (wr_ls) begin
      ls_div <= reg_wdata[PS_W-1:0];
      ls_cnt <= '0;
    end else if (ls_stb) ls_cnt <= '0;
    else ls_cnt <= ls_cnt + CW'(1);
  end

  // external interface ticks
  assign xtim_stb = !ctrl[0] || tph;
  assign xout_stb = !ctrl[2] && xtim_stb && (!ctrl[1] || oph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      tph  <= 1'b0;
      oph  <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl <= reg_wdata[3:0];
      tph  <= 1'b0;
      oph  <= 1'b0;
    end else begin
      tph <= !tph;
      if (xtim_stb) oph <= !oph;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else for (int k = 0; k < 3; k++)
      if (reg_we && reg_addr == 3'(3 + k)) en[k*REG_W +: REG_W] <= reg_wdata[REG_W-1:0];
  end

  assign periph_en = en;
  assign acc_ok    = en;
  assign pwm_tb_en = en[REG_W +: N_PWM] & {N_PWM{ctrl[3]}};

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = DW'(hs_div);
      3'd1:    reg_rdata = DW'(ls_div);
      3'd2:    reg_rdata = DW'(ctrl);
      3'd3:    reg_rdata = DW'(en[0 +: REG_W]);
      3'd4:    reg_rdata = DW'(en[REG_W +: REG_W]);
      3'd5:    reg_rdata = DW'(en[2*REG_W +: REG_W]);
      default: reg_rdata = '0;
    endcase
  end

  // peripheral-side access gating
  wire [NP-1:0] pa_hot = NP'(1) << pa_id;
  assign pa_rd_stb    = pa_rd ? (pa_hot & en) : '0;
  assign pa_wr_stb    = pa_wr ? (pa_hot & en) : '0;
  assign pa_rdata_out = (|pa_rd_stb) ? pa_rdata_in : '0;
endmodule

module pclk_gate_chk #(
  parameter int PS_W  = 3,
  parameter int REG_W = 16,
  parameter int N_PWM = 6,
  parameter int DW    = 16,
  parameter int NP    = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [PS_W-1:0]  w_ps,
  input logic             w_off,
  input logic [PS_W-1:0]  hs_div,
  input logic [PS_W-1:0]  ls_div,
  input logic             tim_half,
  input logic             sync,
  input logic             hs_stb,
  input logic             ls_stb,
  input logic             xtim_stb,
  input logic             xout_stb,
  input logic [NP-1:0]    periph_en,
  input logic [N_PWM-1:0] pwm_tb_en,
  input logic [NP-1:0]    pa_rd_stb,
  input logic [NP-1:0]    pa_wr_stb,
  input logic [DW-1:0]    pa_rdata_out
);
  // R2
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_stb && hs_div != '0 && !(reg_we && reg_addr == 3'd0)) |=> !hs_stb);
  // R2
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_stb && ls_div != '0 && !(reg_we && reg_addr == 3'd1)) |=> !ls_stb);
  // R4
  hs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && w_ps != '0) |=> !hs_stb);
  // R5
  tim_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_half && xtim_stb && !(reg_we && reg_addr == 3'd2)) |=> !xtim_stb);
  // R6
  out_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xout_stb |-> xtim_stb);
  // R6
  out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2 && w_off) |=> !xout_stb);
  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == 3'd3 || reg_addr == 3'd4 || reg_addr == 3'd5)) |=> $stable(periph_en));
  // R8
  pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_tb_en & ~periph_en[REG_W +: N_PWM]) == '0);
  // R8
  pwm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> pwm_tb_en == periph_en[REG_W +: N_PWM]);
  // R9
  wr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pa_wr_stb) && $onehot0(pa_rd_stb));
  // R9
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_wr_stb | pa_rd_stb) & ~periph_en) == '0);
  // R10
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_rd_stb == '0) |-> pa_rdata_out == '0);
  // R11
  unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr > 3'd5) |=> ($stable(periph_en) && $stable(hs_div) && $stable(ls_div)));
endmodule

bind pclk_gate pclk_gate_chk #(
  .PS_W(PS_W), .REG_W(REG_W), .N_PWM(N_PWM), .DW(DW), .NP(NP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .w_ps(reg_wdata[PS_W-1:0]), .w_off(reg_wdata[2]),
  .hs_div(hs_div), .ls_div(ls_div), .tim_half(ctrl[0]), .sync(ctrl[3]),
  .hs_stb(hs_stb), .ls_stb(ls_stb), .xtim_stb(xtim_stb), .xout_stb(xout_stb),
  .periph_en(periph_en), .pwm_tb_en(pwm_tb_en),
  .pa_rd_stb(pa_rd_stb), .pa_wr_stb(pa_wr_stb), .pa_rdata_out(pa_rdata_out)
);

// File: tb/test_pclk_gate.sv
module test_pclk_gate;
  localparam int PS_W = 3, REG_W = 8, N_PWM = 4, DW = 16;
  localparam int NP = 3 * REG_W, PID_W = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic hs_stb, ls_stb, xtim_stb, xout_stb;
  logic [NP-1:0] periph_en, acc_ok, pa_rd_stb, pa_wr_stb;
  logic [N_PWM-1:0] pwm_tb_en;
  logic pa_rd = 1'b0, pa_wr = 1'b0;
  logic [PID_W-1:0] pa_id = '0;
  logic [DW-1:0] pa_rdata_in = '0, pa_rdata_out;

  int checks = 0, errs = 0;
  bit done = 0;

  always #5 clk = !clk;

  pclk_gate #(.PS_W(PS_W), .REG_W(REG_W), .N_PWM(N_PWM), .DW(DW)) i_pclk_gate (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hs_stb(hs_stb), .ls_stb(ls_stb),
    .xtim_stb(xtim_stb), .xout_stb(xout_stb), .periph_en(periph_en),
    .pwm_tb_en(pwm_tb_en), .acc_ok(acc_ok), .pa_rd(pa_rd), .pa_wr(pa_wr),
    .pa_id(pa_id), .pa_rdata_in(pa_rdata_in), .pa_rdata_out(pa_rdata_out),
    .pa_rd_stb(pa_rd_stb), .pa_wr_stb(pa_wr_stb));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: ages count cycles since the last restart
  int m_hs, m_ls, m_ctrl, m_hage, m_lage, m_tage, m_ticks;
  logic [NP-1:0] m_en;

  function automatic bit f_pre(input int n, input int age);
    return (n == 0) || ((age % (2 * n)) == 2 * n - 1);
  endfunction
  function automatic bit f_tim();
    return !m_ctrl[0] || (m_tage % 2 == 1);
  endfunction
  function automatic bit f_out();
    return !m_ctrl[2] && f_tim() && (!m_ctrl[1] || (m_ticks % 2 == 1));
  endfunction
  function automatic logic [DW-1:0] f_rd(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_hs);
      3'd1: return DW'(m_ls);
      3'd2: return DW'(m_ctrl);
      3'd3: return DW'(m_en[7:0]);
      3'd4: return DW'(m_en[15:8]);
      3'd5: return DW'(m_en[23:16]);
      default: return '0;
    endcase
  endfunction
  function automatic logic [NP-1:0] f_hot();
    return (int'(pa_id) < NP) ? (NP'(1) << pa_id) & m_en : '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hs = 1; m_ls = 2; m_ctrl = 0; m_en = '0;
      m_hage = 0; m_lage = 0; m_tage = 0; m_ticks = 0;
    end else begin
      bit tick_now;
      tick_now = f_tim();
      if (reg_we && reg_addr == 0) begin m_hs = int'(reg_wdata[2:0]); m_hage = 0; end
      else m_hage++;
      if (reg_we && reg_addr == 1) begin m_ls = int'(reg_wdata[2:0]); m_lage = 0; end
      else m_lage++;
      if (reg_we && reg_addr == 2) begin m_ctrl = int'(reg_wdata[3:0]); m_tage = 0; m_ticks = 0; end
      else begin m_tage++; if (tick_now) m_ticks++; end
      if (reg_we && reg_addr == 3) m_en[7:0]   = reg_wdata[7:0];
      if (reg_we && reg_addr == 4) m_en[15:8]  = reg_wdata[7:0];
      if (reg_we && reg_addr == 5) m_en[23:16] = reg_wdata[7:0];
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 hs_stb", 32'(hs_stb), 32'(f_pre(m_hs, m_hage)));
      chk("R2 ls_stb", 32'(ls_stb), 32'(f_pre(m_ls, m_lage)));
      chk("R5 xtim_stb", 32'(xtim_stb), 32'(f_tim()));
      chk("R6 xout_stb", 32'(xout_stb), 32'(f_out()));
      chk("R7 periph_en", 32'(periph_en), 32'(m_en));
      chk("R7 acc_ok", 32'(acc_ok), 32'(m_en));
      chk("R8 pwm_tb_en", 32'(pwm_tb_en), m_ctrl[3] ? 32'(m_en[11:8]) : 32'd0);
      chk("R11 reg_rdata", 32'(reg_rdata), 32'(f_rd(reg_addr)));
      chk("R9 pa_wr_stb", 32'(pa_wr_stb), pa_wr ? 32'(f_hot()) : 32'd0);
      chk("R9 pa_rd_stb", 32'(pa_rd_stb), pa_rd ? 32'(f_hot()) : 32'd0);
      chk("R10 pa_rdata_out", 32'(pa_rdata_out),
          (pa_rd && f_hot() != '0) ? 32'(pa_rdata_in) : 32'd0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [DW-1:0] exp);
    reg_addr = a; #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 hs field", 3'd0, 16'd1);
    rd_chk("R1 ls field", 3'd1, 16'd2);
    rd_chk("R1 ctrl", 3'd2, 16'd0);
    rd_chk("R1 en0", 3'd3, 16'd0);
    rd_chk("R1 en1", 3'd4, 16'd0);
    rd_chk("R1 en2", 3'd5, 16'd0);
    chk("R1 periph_en", 32'(periph_en), 32'd0);
    repeat (30) step();

    // R3 zero field, R2 large field
    wr(3'd0, 16'd0);
    for (int k = 0; k < 4; k++) begin chk("R3 hs every cycle", 32'(hs_stb), 32'd1); step(); end
    wr(3'd1, 16'd7);
    for (int k = 0; k < 14; k++) begin chk("R2 ls div14", 32'(ls_stb), 32'(k == 13)); step(); end
    repeat (40) step();

    // R4 restart on write
    repeat (3) step();
    wr(3'd0, 16'hFFF3);
    rd_chk("R4 field bits only", 3'd0, 16'd3);
    for (int k = 0; k < 6; k++) begin chk("R4 restart", 32'(hs_stb), 32'(k == 5)); step(); end

    // R5 / R6 interface ticks
    wr(3'd2, 16'd1);
    for (int k = 0; k < 4; k++) begin chk("R5 tim half", 32'(xtim_stb), 32'(k % 2 == 1)); step(); end
    wr(3'd2, 16'd3);
    for (int k = 0; k < 8; k++) begin chk("R6 out quarter", 32'(xout_stb), 32'(k == 3 || k == 7)); step(); end
    wr(3'd2, 16'd2);
    for (int k = 0; k < 6; k++) begin chk("R6 out half", 32'(xout_stb), 32'(k % 2 == 1)); step(); end
    wr(3'd2, 16'd6);
    for (int k = 0; k < 6; k++) begin chk("R6 out off", 32'(xout_stb), 32'd0); step(); end

    // R7 enable groups
    wr(3'd3, 16'h00A5);
    wr(3'd4, 16'h000F);
    wr(3'd5, 16'h0080);
    rd_chk("R7 en0 read", 3'd3, 16'h00A5);
    rd_chk("R7 en1 read", 3'd4, 16'h000F);
    rd_chk("R7 en2 read", 3'd5, 16'h0080);
    chk("R7 periph_en", 32'(periph_en), 32'h800FA5);

    // R8 synchronised timebase start
    wr(3'd2, 16'd0);
    chk("R8 held low", 32'(pwm_tb_en), 32'd0);
    wr(3'd2, 16'd8);
    chk("R8 all start", 32'(pwm_tb_en), 32'hF);
    wr(3'd4, 16'h0005);
    chk("R8 partial", 32'(pwm_tb_en), 32'h5);

    // R9 / R10 peripheral access
    pa_rdata_in = 16'h1234;
    pa_wr = 1'b1; pa_id = 5'd0; #1;
    chk("R9 enabled write", 32'(pa_wr_stb), 32'h1);
    pa_id = 5'd1; #1;
    chk("R9 gated write", 32'(pa_wr_stb), 32'h0);
    pa_id = 5'd30; #1;
    chk("R9 out of range", 32'(pa_wr_stb), 32'h0);
    pa_wr = 1'b0; pa_rd = 1'b1; pa_id = 5'd1; #1;
    chk("R10 gated read", 32'(pa_rdata_out), 32'h0);
    pa_id = 5'd23; #1;
    chk("R10 enabled read", 32'(pa_rdata_out), 32'h1234);
    chk("R9 read strobe", 32'(pa_rd_stb), 32'h800000);
    pa_rd = 1'b0;

    // R11 unused addresses
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd_chk("R11 addr6 zero", 3'd6, 16'd0);
    rd_chk("R11 addr7 zero", 3'd7, 16'd0);
    rd_chk("R11 hs kept", 3'd0, 16'd3);
    chk("R11 en kept", 32'(periph_en), 32'h8005A5);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      step();
      reg_we    = ($urandom % 6) == 0;
      reg_addr  = 3'($urandom);
      reg_wdata = 16'($urandom);
      pa_rd     = 1'($urandom);
      pa_wr     = 1'($urandom);
      pa_id     = 5'($urandom);
      pa_rdata_in = 16'($urandom);
    end
    step();
    reg_we = 1'b0; pa_rd = 1'b0; pa_wr = 1'b0;
    repeat (4) step();

    done = 1;
    summary();
    $finish;
  end
endmodule